// File: doc/BRIEF.md
# ULPI Link-Side Register Write Sequencer

This block runs the link side of a register write to a ULPI transceiver. A requester hands over one register address and one data byte through a valid/ready handshake. The block then owns the shared 8-bit bus for the whole write. It waits until the transceiver has turned the bus over (direction low) and sends a transmit command byte. It moves through the phases only when the transceiver raises NXT, marks the end of the write with a one-cycle STP, and leaves the bus at the idle value 00h.

Two write forms exist, and they differ in length. The short form puts a 6-bit address straight into the command byte. The long form sends a fixed command code, then the full 8-bit address as a separate byte, then the data. If the transceiver takes the bus back during a write, the block releases its drivers, pulses an abort flag and starts the same write again from the command byte once the bus is free.

Top module: `ulpi_regwr_ctrl`

## Requirements
- R1: While reset is held, req_ready is 1 and busy, ulpi_data_oe, ulpi_stp, done and abort are all 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle busy is 1 and req_ready is 0 until the write ends. While busy, changes on req_valid, req_addr and req_data have no effect on the bytes driven.
- R3: If ulpi_dir is high when a request is taken, the block keeps ulpi_data_oe at 0 and waits. The command byte appears in the cycle after the first edge that samples ulpi_dir low.
- R4: A short write drives the command byte {2'b10, addr[5:0]}. That byte stays on the bus in every cycle until an edge samples ulpi_nxt high.
- R5: The long form is used when req_ext is 1, when addr[7:6] is non-zero, or when addr[5:0] equals 6'h2F. Its command byte is 8'hAF. In the cycle after the edge where NXT accepts it, the bus carries the full 8-bit address.
- R6: After the command byte (short form) or the address byte (long form) is accepted, the data byte is driven. It stays on the bus until an edge samples ulpi_nxt high.
- R7: In the cycle after the data byte is accepted, ulpi_stp is 1 with 00h on the bus. In the next cycle ulpi_stp is 0 and 00h is still driven.
- R8: done is 1 for exactly one cycle: the cycle after the STP cycle. busy returns to 0 in the following cycle.
- R9: If ulpi_dir is sampled high during the command, address or data phase, abort is 1 for one cycle with ulpi_data_oe at 0. The same write then restarts from the command byte once ulpi_dir is sampled low.
- R10: ulpi_data_oe goes to 0 in the cycle after ulpi_dir is first sampled high, never earlier. While idle with ulpi_dir low, the block drives 00h with ulpi_data_oe at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 8 | Target register address |
| req_data | input | 8 | Byte to write |
| req_ext | input | 1 | Force the long (extended-address) form |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when a write has completed |
| abort | output | 1 | One-cycle pulse when the transceiver took the bus mid-write |
| ulpi_dir | input | 1 | Bus direction from the transceiver (high = transceiver drives) |
| ulpi_nxt | input | 1 | Transceiver throttle: current byte accepted |
| ulpi_stp | output | 1 | End-of-transfer strobe |
| ulpi_data_o | output | 8 | Byte driven toward the transceiver |
| ulpi_data_oe | output | 1 | Output enable for ulpi_data_o |

## Verification
The hardest case to reach from the ports is a turnaround in the middle of a write. The transceiver has to raise DIR while the long form is between its address and data bytes, and the retry has to go through the whole sequence again with the original request. The bench models the transceiver itself. It raises DIR in the cycle the address byte is on the bus and holds it for several cycles. It then checks the abort pulse, the released bus, the one-cycle delay of the enable drop, and the replayed command, address and data bytes.

// File: rtl/ulpi_wr_pkg.sv
package ulpi_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_CMD,
      ST_EXT,
      ST_DATA,
      ST_STP,
      ST_FIN,
      ST_ABORT
   } wr_state_e;

   localparam logic [7:0] BUS_IDLE  = 8'h00;
   localparam logic [1:0] OP_REGWR  = 2'b10;
   localparam logic [5:0] EXT_SLOT  = 6'h2F;

endpackage

// File: rtl/ulpi_wr_req.sv
module ulpi_wr_req
   import ulpi_wr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              ext_req,
   output logic [DATA_W-1:0] cmd_byte,
   output logic [DATA_W-1:0] addr_byte,
   output logic [DATA_W-1:0] data_byte,
   output logic              is_ext
);

   localparam int IMM_W = DATA_W - $bits(OP_REGWR);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("ulpi_wr_req: DATA_W must be 8");
      end
      if (ADDR_W != DATA_W) begin : g_bad_addr_w
         $error("ulpi_wr_req: ADDR_W must equal DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              ext_q;
   logic              hi_set;
   logic              slot_hit;

   // upper address bits cannot fit into the immediate field
   generate
      if (ADDR_W > IMM_W) begin : g_hi
         assign hi_set = |addr[ADDR_W-1:IMM_W];
      end else begin : g_no_hi
         assign hi_set = 1'b0;
      end
   endgenerate

   // the reserved slot would alias the long-form command code
   assign slot_hit = (addr[IMM_W-1:0] == EXT_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         ext_q  <= 1'b0;
      end else if (load) begin
         addr_q <= addr;
         data_q <= data;
         ext_q  <= ext_req | hi_set | slot_hit;
      end
   end

   assign is_ext    = ext_q;
   assign addr_byte = addr_q;
   assign data_byte = data_q;
   assign cmd_byte  = ext_q ? {OP_REGWR, EXT_SLOT} : {OP_REGWR, addr_q[IMM_W-1:0]};

endmodule

// File: rtl/ulpi_wr_fsm.sv
module ulpi_wr_fsm
   import ulpi_wr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      dir,
   input  logic      nxt,
   input  logic      is_ext,
   output wr_state_e state,
   output logic      load,
   output logic      ready,
   output logic      busy,
   output logic      done,
   output logic      abort,
   output logic      stp
);

   wr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = dir ? ST_WAIT : ST_CMD;
         ST_WAIT:  if (!dir) state_d = ST_CMD;
         ST_CMD: begin
            if (dir)      state_d = ST_ABORT;
            else if (nxt) state_d = is_ext ? ST_EXT : ST_DATA;
         end
         ST_EXT: begin
            if (dir)      state_d = ST_ABORT;
            else if (nxt) state_d = ST_DATA;
         end
         ST_DATA: begin
            if (dir)      state_d = ST_ABORT;
            else if (nxt) state_d = ST_STP;
         end
         ST_STP:   state_d = ST_FIN;
         ST_FIN:   state_d = ST_IDLE;
         ST_ABORT: state_d = ST_WAIT;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;
   assign ready = (state_q == ST_IDLE);
   assign load  = ready & req_valid;
   assign busy  = !ready;
   assign stp   = (state_q == ST_STP);
   assign done  = (state_q == ST_FIN);
   assign abort = (state_q == ST_ABORT);

endmodule

// File: rtl/ulpi_wr_drive.sv
module ulpi_wr_drive
   import ulpi_wr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir,
   input  wr_state_e         state,
   input  logic [DATA_W-1:0] cmd_byte,
   input  logic [DATA_W-1:0] addr_byte,
   input  logic [DATA_W-1:0] data_byte,
   output logic [DATA_W-1:0] bus_o,
   output logic              bus_oe
);

   logic own_q;
   logic drive_st;

   // bus ownership follows the sampled direction with one cycle of turnaround
   always_ff @(posedge clk) begin
      if (!rst_n) own_q <= 1'b0;
      else        own_q <= !dir;
   end

   always_comb begin
      drive_st = 1'b1;
      bus_o    = BUS_IDLE;
      unique case (state)
         ST_CMD:   bus_o = cmd_byte;
         ST_EXT:   bus_o = addr_byte;
         ST_DATA:  bus_o = data_byte;
         ST_WAIT,
         ST_ABORT: drive_st = 1'b0;
         default:  bus_o = BUS_IDLE;
      endcase
   end

   assign bus_oe = own_q & drive_st;

endmodule

// File: rtl/ulpi_regwr_ctrl.sv
module ulpi_regwr_ctrl
   import ulpi_wr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_ext,
   output logic              busy,
   output logic              done,
   output logic              abort,
   input  logic              ulpi_dir,
   input  logic              ulpi_nxt,
   output logic              ulpi_stp,
   output logic [DATA_W-1:0] ulpi_data_o,
   output logic              ulpi_data_oe
);

   wr_state_e         state;
   logic              load;
   logic              is_ext;
   logic [DATA_W-1:0] cmd_byte;
   logic [DATA_W-1:0] addr_byte;
   logic [DATA_W-1:0] data_byte;

   ulpi_wr_req #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .addr      (req_addr),
      .data      (req_data),
      .ext_req   (req_ext),
      .cmd_byte  (cmd_byte),
      .addr_byte (addr_byte),
      .data_byte (data_byte),
      .is_ext    (is_ext)
   );

   ulpi_wr_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .dir       (ulpi_dir),
      .nxt       (ulpi_nxt),
      .is_ext    (is_ext),
      .state     (state),
      .load      (load),
      .ready     (req_ready),
      .busy      (busy),
      .done      (done),
      .abort     (abort),
      .stp       (ulpi_stp)
   );

   ulpi_wr_drive #(
      .DATA_W (DATA_W)
   ) u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir       (ulpi_dir),
      .state     (state),
      .cmd_byte  (cmd_byte),
      .addr_byte (addr_byte),
      .data_byte (data_byte),
      .bus_o     (ulpi_data_o),
      .bus_oe    (ulpi_data_oe)
   );

endmodule

// File: rtl/ulpi_wr_checker.sv
module ulpi_wr_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              busy,
   input logic              done,
   input logic              abort,
   input logic              ulpi_dir,
   input logic              ulpi_stp,
   input logic [DATA_W-1:0] ulpi_data_o,
   input logic              ulpi_data_oe
);

   assert_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy);

   assert_stp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ulpi_stp |=> !ulpi_stp);

   assert_stp_idle_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ulpi_stp |-> (ulpi_data_oe && ulpi_data_o == '0));

   assert_done_after_stp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ulpi_stp |=> done);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_abort_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> !ulpi_data_oe);

   assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ulpi_dir |=> !ulpi_data_oe);

endmodule

bind ulpi_regwr_ctrl ulpi_wr_checker #(.DATA_W(DATA_W)) u_wr_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .busy         (busy),
   .done         (done),
   .abort        (abort),
   .ulpi_dir     (ulpi_dir),
   .ulpi_stp     (ulpi_stp),
   .ulpi_data_o  (ulpi_data_o),
   .ulpi_data_oe (ulpi_data_oe)
);

// File: tb/test_ulpi_regwr_ctrl.sv
module test_ulpi_regwr_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic       req_ext = 1'b0;
   logic       busy, done, abort;
   logic       ulpi_dir = 1'b0;
   logic       ulpi_nxt = 1'b0;
   logic       ulpi_stp;
   logic [7:0] ulpi_data_o;
   logic       ulpi_data_oe;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   ulpi_regwr_ctrl i_ulpi_regwr_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_data     (req_data),
      .req_ext      (req_ext),
      .busy         (busy),
      .done         (done),
      .abort        (abort),
      .ulpi_dir     (ulpi_dir),
      .ulpi_nxt     (ulpi_nxt),
      .ulpi_stp     (ulpi_stp),
      .ulpi_data_o  (ulpi_data_o),
      .ulpi_data_oe (ulpi_data_oe)
   );

   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] data;
      logic       ext;
      logic [3:0] hold;
      logic [7:0] cmd;
      logic       long_form;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{addr: 8'h04, data: 8'h5A, ext: 1'b0, hold: 4'd0, cmd: 8'h84, long_form: 1'b0},
      '{addr: 8'h16, data: 8'hC3, ext: 1'b0, hold: 4'd3, cmd: 8'h96, long_form: 1'b0},
      '{addr: 8'h3F, data: 8'hFF, ext: 1'b0, hold: 4'd1, cmd: 8'hBF, long_form: 1'b0},
      '{addr: 8'h45, data: 8'h11, ext: 1'b0, hold: 4'd0, cmd: 8'hAF, long_form: 1'b1},
      '{addr: 8'h07, data: 8'h80, ext: 1'b1, hold: 4'd2, cmd: 8'hAF, long_form: 1'b1},
      '{addr: 8'h2F, data: 8'h3C, ext: 1'b0, hold: 4'd0, cmd: 8'hAF, long_form: 1'b1}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_write(input vec_t v);
      req_valid = 1'b1; req_addr = v.addr; req_data = v.data; req_ext = v.ext;
      check("R2", "ready before take", req_ready, 1);
      tick;
      // keep a competing request on the inputs: it must change nothing (R2)
      req_addr = ~v.addr; req_data = ~v.data; req_ext = ~v.ext;
      check("R2", "ready while busy", req_ready, 0);
      check("R2", "busy after take", busy, 1);
      check("R4", "command byte", ulpi_data_o, v.cmd);
      check("R4", "command enable", ulpi_data_oe, 1);
      for (int i = 0; i < int'(v.hold); i++) begin
         tick;
         check("R4", "command held without nxt", ulpi_data_o, v.cmd);
      end
      ulpi_nxt = 1'b1;
      tick;
      if (v.long_form) begin
         check("R5", "address byte", ulpi_data_o, v.addr);
         tick;
      end
      req_valid = 1'b0;
      check("R6", "data byte", ulpi_data_o, v.data);
      check("R6", "data enable", ulpi_data_oe, 1);
      tick;
      ulpi_nxt = 1'b0;
      check("R7", "stp high", ulpi_stp, 1);
      check("R7", "idle during stp", ulpi_data_o, 0);
      tick;
      check("R7", "stp low after", ulpi_stp, 0);
      check("R7", "idle after stp", ulpi_data_o, 0);
      check("R8", "done pulse", done, 1);
      tick;
      check("R8", "done cleared", done, 0);
      check("R8", "busy cleared", busy, 0);
      check("R10", "idle drive enable", ulpi_data_oe, 1);
      check("R10", "idle drive value", ulpi_data_o, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      // R1: state held in reset
      check("R1", "ready in reset", req_ready, 1);
      check("R1", "busy in reset", busy, 0);
      check("R1", "oe in reset", ulpi_data_oe, 0);
      check("R1", "stp in reset", ulpi_stp, 0);
      check("R1", "done in reset", done, 0);
      check("R1", "abort in reset", abort, 0);
      tick;
      rst_n = 1'b1;
      tick;
      check("R10", "idle drives after dir low", ulpi_data_oe, 1);

      for (int k = 0; k < NV; k++) run_write(VECS[k]);

      // R10 / R3: transceiver owns the bus before the request
      ulpi_dir = 1'b1;
      check("R10", "oe before edge", ulpi_data_oe, 1);
      tick;
      check("R10", "oe dropped one cycle later", ulpi_data_oe, 0);
      req_valid = 1'b1; req_addr = 8'h01; req_data = 8'h42; req_ext = 1'b0;
      tick;
      req_valid = 1'b0;
      check("R3", "waits with bus released", ulpi_data_oe, 0);
      check("R3", "busy while waiting", busy, 1);
      tick;
      check("R3", "still released", ulpi_data_oe, 0);
      ulpi_dir = 1'b0;
      tick;
      check("R3", "command after dir low", ulpi_data_o, 8'h81);
      check("R3", "enable after dir low", ulpi_data_oe, 1);
      ulpi_nxt = 1'b1;
      tick;
      check("R6", "data after wait", ulpi_data_o, 8'h42);
      tick;
      ulpi_nxt = 1'b0;
      check("R7", "stp after wait", ulpi_stp, 1);
      tick;
      check("R8", "done after wait", done, 1);
      tick;

      // R9: turnaround during the address phase of a long write
      req_valid = 1'b1; req_addr = 8'h50; req_data = 8'h99; req_ext = 1'b0;
      tick;
      req_valid = 1'b0;
      check("R5", "long command", ulpi_data_o, 8'hAF);
      ulpi_nxt = 1'b1;
      tick;
      check("R5", "address before abort", ulpi_data_o, 8'h50);
      ulpi_dir = 1'b1; ulpi_nxt = 1'b0;
      tick;
      check("R9", "abort pulse", abort, 1);
      check("R9", "bus released", ulpi_data_oe, 0);
      tick;
      check("R9", "abort single cycle", abort, 0);
      check("R9", "busy after abort", busy, 1);
      check("R9", "released while dir high", ulpi_data_oe, 0);
      tick;
      ulpi_dir = 1'b0;
      tick;
      check("R9", "retry command", ulpi_data_o, 8'hAF);
      check("R9", "retry enable", ulpi_data_oe, 1);
      ulpi_nxt = 1'b1;
      tick;
      check("R9", "retry address", ulpi_data_o, 8'h50);
      tick;
      check("R9", "retry data", ulpi_data_o, 8'h99);
      tick;
      ulpi_nxt = 1'b0;
      check("R9", "retry stp", ulpi_stp, 1);
      tick;
      check("R9", "retry done", done, 1);
      tick;
      check("R8", "idle after retry", busy, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule